// File: doc/BRIEF.md
# Byte-Wide Serial Port with Four-Entry Receive Queue

This block is a small asynchronous serial port for a processor bus. It sends and receives frames of one start bit, eight data bits (least significant first) and one stop bit, with no parity. Software sees eight byte-wide registers, one per 32-bit word:

- four read-only identity bytes;
- a data register;
- a status byte that mixes flags, sticky error bits and two interrupt enables;
- a 16-bit bit-rate divisor split into two bytes.

The transmit side has one holding register. The receive side stores up to four characters and flags framing and overrun errors. Both directions drive a single interrupt line.

The divisor D sets a tick that fires every D+1 clocks. Each bit on the line lasts four ticks, so software loads D = clock / (rate × 4) − 1.

The transmitter is a state machine with four states:

- `TX_IDLE`: the line is high. When a character is held, it moves to `TX_START` on the next tick.
- `TX_START`: drives the start bit for four ticks, then moves to `TX_DATA`.
- `TX_DATA`: drives each data bit for four ticks. After the eighth bit it moves to `TX_STOP`.
- `TX_STOP`: drives the stop bit for four ticks, then returns to `TX_IDLE` and marks the holding register empty.

The receiver is a state machine with four states:

- `RX_IDLE`: moves to `RX_HUNT` on a tick that sees the line low.
- `RX_HUNT`: looks at the line again two ticks later. If the line is high it returns to `RX_IDLE`; if it is still low it moves to `RX_DATA`.
- `RX_DATA`: samples a data bit every four ticks. After eight bits it moves to `RX_STOP`.
- `RX_STOP`: samples the stop bit four ticks later, delivers the character and returns to `RX_IDLE`.

Top module: `byte_uart`

## Requirements
- R1: After reset the status byte reads 0xA0 (transmit empty and receive empty set, every other bit 0), both divisor bytes read 0, and the identity bytes at offsets 0, 4, 8 and 12 return bits 7:0, 15:8, 23:16 and 31:24 of the ID_WORD parameter.
- R2: Registers sit at byte offsets 16 (data), 20 (status), 24 (divisor low) and 28 (divisor high). The divisor bytes read back what was written. An access whose two low address bits are not 00 reads 0 and writes nothing.
- R3: A transmitted frame has a low start bit, eight data bits with the least significant first, and a high stop bit. Each bit lasts 4 × (divisor + 1) clocks.
- R4: Status bit 7 (transmit empty) clears when the data register is written and sets again after the stop bit ends. A data write while bit 7 is 0 is dropped.
- R5: A frame received on the serial input is stored, and reads of the data register return the stored characters in arrival order, removing one per read.
- R6: Status bit 5 is 1 when the queue is empty. Bit 4 is 1 when it holds exactly three characters. Bit 3 is 1 when it holds four.
- R7: A character that completes while four are stored is discarded and sets status bit 1, and the stored four are kept. A read and a completing character in the same cycle on a full queue is not an overrun.
- R8: A frame whose stop bit samples low sets status bit 0, and the character is still stored.
- R9: A status write loads bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable). A 0 written to bit 0 or bit 1 clears that error, and a 1 leaves it unchanged. Bits 3, 4, 5 and 7 ignore writes.
- R10: A low pulse on the serial input that has ended by the mid-start-bit check stores nothing.
- R11: Reading the data register while the queue is empty returns the last character read and leaves the queue flags unchanged.
- R12: The interrupt output equals (bit 2 AND (NOT bit 5 OR bit 0 OR bit 1)) OR (bit 6 AND bit 7) of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a data-register read removes one character |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Shared interrupt request |

## Verification
On a full queue, a software read of the data register and the receiver delivering a fifth character can fall in the same cycle. If the read comes first, or in the same cycle, the new character must be accepted. If it comes later, the character must be dropped as an overrun.

The bench fills the queue with four characters. It then sends a fifth while issuing one read, and sweeps the read cycle one clock at a time across the stop-bit window. After each trial it drains the queue and accepts only two outcomes:
- no overrun, with the second to fifth characters in order;
- an overrun, with exactly the second to fourth characters.

Across the sweep both outcomes must appear.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;
    localparam logic [2:0] SEL_ID0   = 3'd0;
    localparam logic [2:0] SEL_ID1   = 3'd1;
    localparam logic [2:0] SEL_ID2   = 3'd2;
    localparam logic [2:0] SEL_ID3   = 3'd3;
    localparam logic [2:0] SEL_DATA  = 3'd4;
    localparam logic [2:0] SEL_STAT  = 3'd5;
    localparam logic [2:0] SEL_DIVLO = 3'd6;
    localparam logic [2:0] SEL_DIVHI = 3'd7;

    localparam int ST_FERR    = 0;
    localparam int ST_OERR    = 1;
    localparam int ST_RXIE    = 2;
    localparam int ST_RXFULL  = 3;
    localparam int ST_RXONE   = 4;
    localparam int ST_RXEMPTY = 5;
    localparam int ST_TXIE    = 6;
    localparam int ST_TXEMPTY = 7;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/byte_uart_rxq.sv
module byte_uart_rxq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         one_left,
    output logic         overflow
);
    localparam int P_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int C_W = $clog2(DEPTH + 1);
    localparam logic [C_W-1:0] C_MAX = C_W'(DEPTH);
    localparam logic [P_W-1:0] P_LAST = P_W'(DEPTH - 1);

    logic [W-1:0]   mem [DEPTH];
    logic [P_W-1:0] wp, rp;
    logic [C_W-1:0] cnt;
    logic           do_push, do_pop;

    function automatic logic [P_W-1:0] nxt(input logic [P_W-1:0] p);
        return (p == P_LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == C_MAX);
    assign one_left = (cnt == C_MAX - 1'b1);
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign overflow = push && !do_push;
    assign dout     = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= C_MAX);
    p_full_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt == C_MAX));
    p_empty_read_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (cnt == '0));
endmodule

// File: rtl/byte_uart_tx.sv
module byte_uart_tx
    import byte_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              hold_empty
);
    localparam int Q_W = $clog2(OVS);
    localparam int B_W = $clog2(DATA_W);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(OVS - 1);
    localparam logic [B_W-1:0] B_LAST = B_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [Q_W-1:0]    q_cnt;
    logic [B_W-1:0]    b_cnt;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              slot_end;

    assign slot_end = tick && (q_cnt == Q_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (!hold_empty && tick) state_d = TX_START;
            TX_START: if (slot_end) state_d = TX_DATA;
            TX_DATA:  if (slot_end && b_cnt == B_LAST) state_d = TX_STOP;
            TX_STOP:  if (slot_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cnt      <= '0;
            b_cnt      <= '0;
            hold_q     <= '0;
            shift_q    <= '0;
            hold_empty <= 1'b1;
        end else begin
            if (load && hold_empty) begin
                hold_q     <= load_data;
                hold_empty <= 1'b0;
            end
            if (state_q == TX_IDLE) begin
                q_cnt <= '0;
                b_cnt <= '0;
                if (state_d == TX_START) shift_q <= hold_q;
            end else if (tick) begin
                q_cnt <= slot_end ? '0 : q_cnt + 1'b1;
                if (slot_end && state_q == TX_DATA) begin
                    shift_q <= shift_q >> 1;
                    b_cnt   <= b_cnt + 1'b1;
                end
                if (slot_end && state_q == TX_STOP) hold_empty <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    p_busy_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !hold_empty) |=> $stable(hold_q));
    p_frame_holds_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE) |-> !hold_empty);
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx
    import byte_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_ferr
);
    localparam int Q_W = $clog2(OVS);
    localparam int B_W = $clog2(DATA_W);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(OVS - 1);
    localparam logic [Q_W-1:0] Q_MID  = Q_W'(OVS / 2 - 1);
    localparam logic [B_W-1:0] B_LAST = B_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [Q_W-1:0]    q_cnt;
    logic [B_W-1:0]    b_cnt;
    logic [DATA_W-1:0] shift_q;
    logic              slot_end, mid_pt;

    assign slot_end = tick && (q_cnt == Q_LAST);
    assign mid_pt   = tick && (q_cnt == Q_MID);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (tick && !line) state_d = RX_HUNT;
            RX_HUNT: if (mid_pt) state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA: if (slot_end && b_cnt == B_LAST) state_d = RX_STOP;
            RX_STOP: if (slot_end) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cnt   <= '0;
            b_cnt   <= '0;
            shift_q <= '0;
        end else if (state_q == RX_IDLE) begin
            q_cnt <= '0;
            b_cnt <= '0;
        end else if (state_q == RX_HUNT) begin
            if (mid_pt)    q_cnt <= '0;
            else if (tick) q_cnt <= q_cnt + 1'b1;
        end else if (tick) begin
            q_cnt <= slot_end ? '0 : q_cnt + 1'b1;
            if (slot_end && state_q == RX_DATA) begin
                shift_q <= {line, shift_q[DATA_W-1:1]};
                b_cnt   <= b_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        push      = (state_q == RX_STOP) && slot_end;
        push_data = shift_q;
        push_ferr = !line;
    end

    p_hunt_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT) |-> (q_cnt <= Q_MID));
    p_push_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q == RX_IDLE));
endmodule

// File: rtl/byte_uart.sv
module byte_uart
    import byte_uart_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h5A17_C301,
    parameter int          RX_DEPTH = 4,
    parameter int          OVS      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int DIV_W  = 16;
    localparam int DATA_W = 8;

    logic [2:0]        sel;
    logic              aligned, wr_stat, rd_pop, tx_load;
    logic [1:0]        rx_sync;
    logic [DIV_W-1:0]  div_q, div_cnt;
    logic              tick;
    logic              rxie_q, txie_q, ferr_q, oerr_q;
    logic [DATA_W-1:0] last_q, q_dout, rx_data;
    logic              q_empty, q_full, q_one, q_ovf;
    logic              rx_push, rx_ferr, tx_empty;
    logic [7:0]        status;

    assign sel     = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_stat = bus_wr && aligned && (sel == SEL_STAT);
    assign tx_load = bus_wr && aligned && (sel == SEL_DATA);
    assign rd_pop  = bus_rd && aligned && (sel == SEL_DATA);
    assign tick    = (div_cnt >= div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync <= 2'b11;
            div_cnt <= '0;
        end else begin
            rx_sync <= {rx_sync[0], rxd};
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            rxie_q <= 1'b0;
            txie_q <= 1'b0;
            ferr_q <= 1'b0;
            oerr_q <= 1'b0;
            last_q <= '0;
        end else begin
            if (bus_wr && aligned && sel == SEL_DIVLO) div_q[7:0]  <= bus_wdata;
            if (bus_wr && aligned && sel == SEL_DIVHI) div_q[15:8] <= bus_wdata;
            if (wr_stat) begin
                rxie_q <= bus_wdata[ST_RXIE];
                txie_q <= bus_wdata[ST_TXIE];
            end
            if (rx_push && rx_ferr)                  ferr_q <= 1'b1;
            else if (wr_stat && !bus_wdata[ST_FERR]) ferr_q <= 1'b0;
            if (q_ovf)                               oerr_q <= 1'b1;
            else if (wr_stat && !bus_wdata[ST_OERR]) oerr_q <= 1'b0;
            if (rd_pop && !q_empty) last_q <= q_dout;
        end
    end

    byte_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_sync[1]),
        .push(rx_push), .push_data(rx_data), .push_ferr(rx_ferr)
    );

    byte_uart_rxq #(.DEPTH(RX_DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rd_pop), .din(rx_data),
        .dout(q_dout), .empty(q_empty), .full(q_full), .one_left(q_one),
        .overflow(q_ovf)
    );

    byte_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .load_data(bus_wdata), .txd(txd), .hold_empty(tx_empty)
    );

    always_comb begin
        status = '0;
        status[ST_FERR]    = ferr_q;
        status[ST_OERR]    = oerr_q;
        status[ST_RXIE]    = rxie_q;
        status[ST_RXFULL]  = q_full;
        status[ST_RXONE]   = q_one;
        status[ST_RXEMPTY] = q_empty;
        status[ST_TXIE]    = txie_q;
        status[ST_TXEMPTY] = tx_empty;
        irq = (rxie_q && (!q_empty || ferr_q || oerr_q)) || (txie_q && tx_empty);
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_ID0:   bus_rdata = ID_WORD[7:0];
                SEL_ID1:   bus_rdata = ID_WORD[15:8];
                SEL_ID2:   bus_rdata = ID_WORD[23:16];
                SEL_ID3:   bus_rdata = ID_WORD[31:24];
                SEL_DATA:  bus_rdata = q_empty ? last_q : q_dout;
                SEL_STAT:  bus_rdata = status;
                SEL_DIVLO: bus_rdata = div_q[7:0];
                SEL_DIVHI: bus_rdata = div_q[15:8];
                default:   bus_rdata = '0;
            endcase
        end
    end

    p_quiet_when_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxie_q && !txie_q) |-> !irq);
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !(wr_stat && !bus_wdata[ST_FERR])) |=> ferr_q);
    p_ovr_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf |=> oerr_q);
endmodule

// File: tb/byte_uart_tb_top.sv
module byte_uart_tb_top;
    localparam logic [31:0] IDW = 32'h5A17_C301;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int checks = 0, fails = 0;
    int bitc = 16;
    logic rxie_m = 1'b0, txie_m = 1'b0;
    logic [7:0] tx_got[$];

    always #5 clk = ~clk;

    byte_uart #(.ID_WORD(IDW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
        if (a == 5'd20) begin
            rxie_m = d[2];
            txie_m = d[6];
        end
    endtask

    task automatic bread(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit stop_ok);
        @(negedge clk) rxd = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitc) @(negedge clk);
        end
        rxd = stop_ok;
        repeat (bitc) @(negedge clk);
        rxd = 1'b1;
        repeat (bitc) @(negedge clk);
    endtask

    task automatic wait_tx_idle();
        logic [7:0] s;
        for (int k = 0; k < 400; k++) begin
            bread(5'd20, s);
            if (s[7]) break;
        end
    endtask

    task automatic measure_low(output int w);
        @(negedge txd);
        w = 0;
        while (txd == 1'b0) begin
            @(posedge clk);
            #1 w++;
        end
    endtask

    // reference: interrupt must stay low whenever the model has both enables off
    always @(negedge clk) begin
        if (rst_n && !rxie_m && !txie_m) check(irq == 1'b0, "R12 masked", irq, 0);
    end

    // serial line monitor for the transmitter
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge txd);
            repeat (bitc / 2) @(posedge clk);
            #1 check(txd == 1'b0, "R3 start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (bitc) @(posedge clk);
                #1 b[i] = txd;
            end
            repeat (bitc) @(posedge clk);
            #1 check(txd == 1'b1, "R3 stop bit", txd, 1);
            tx_got.push_back(b);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R5 run incomplete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, s;
        int w;
        int n_ovr, n_ok;
        n_ovr = 0;
        n_ok = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        bread(5'd20, v); check(v == 8'hA0, "R1 status", v, 8'hA0);
        bread(5'd24, v); check(v == 8'h00, "R1 div lo", v, 0);
        bread(5'd28, v); check(v == 8'h00, "R1 div hi", v, 0);
        for (int k = 0; k < 4; k++) begin
            bread(5'(4 * k), v);
            check(v == IDW[8*k +: 8], "R1 id byte", v, IDW[8*k +: 8]);
        end

        bwrite(5'd24, 8'd3);
        bread(5'd24, v); check(v == 8'd3, "R2 div readback", v, 3);
        bwrite(5'd25, 8'd9);
        bread(5'd24, v); check(v == 8'd3, "R2 unaligned write dropped", v, 3);
        bread(5'd25, v); check(v == 8'd0, "R2 unaligned read zero", v, 0);

        // transmitter
        bwrite(5'd16, 8'hA5);
        bread(5'd20, v); check(v[7] == 1'b0, "R4 busy flag", v[7], 0);
        bwrite(5'd16, 8'h3C);
        wait_tx_idle();
        repeat (20) @(posedge clk);
        check(tx_got.size() == 1, "R4 busy write dropped", tx_got.size(), 1);
        if (tx_got.size() > 0) check(tx_got[0] == 8'hA5, "R3 tx byte", tx_got[0], 8'hA5);
        bread(5'd20, v); check(v[7] == 1'b1, "R4 empty again", v[7], 1);

        fork
            bwrite(5'd16, 8'h01);
            measure_low(w);
        join
        check(w == 16, "R3 bit width div 3", w, 16);
        wait_tx_idle();
        repeat (20) @(posedge clk);
        bitc = 24;
        bwrite(5'd24, 8'd5);
        fork
            bwrite(5'd16, 8'h01);
            measure_low(w);
        join
        check(w == 24, "R3 bit width div 5", w, 24);
        wait_tx_idle();
        repeat (30) @(posedge clk);
        check(tx_got.size() == 3, "R3 frame count", tx_got.size(), 3);
        if (tx_got.size() == 3) check(tx_got[2] == 8'h01, "R3 tx byte div 5", tx_got[2], 1);
        bwrite(5'd24, 8'd3);
        bitc = 16;

        // receiver
        send(8'h5A, 1'b1);
        bread(5'd20, v); check(v[5] == 1'b0, "R5 data present", v[5], 0);
        bread(5'd16, v); check(v == 8'h5A, "R5 rx byte", v, 8'h5A);
        bread(5'd20, v); check(v[5] == 1'b1, "R5 empty after read", v[5], 1);

        send(8'h11, 1'b1); send(8'h22, 1'b1); send(8'h33, 1'b1);
        bread(5'd20, v); check(v[4:3] == 2'b10, "R6 three stored", v[4:3], 2);
        send(8'h44, 1'b1);
        bread(5'd20, v); check(v[4:3] == 2'b01, "R6 four stored", v[4:3], 1);
        send(8'h55, 1'b1);
        bread(5'd20, v); check(v[1] == 1'b1, "R7 overrun flag", v[1], 1);
        bread(5'd16, v); check(v == 8'h11, "R7 kept 1", v, 8'h11);
        bread(5'd16, v); check(v == 8'h22, "R7 kept 2", v, 8'h22);
        bread(5'd16, v); check(v == 8'h33, "R7 kept 3", v, 8'h33);
        bread(5'd16, v); check(v == 8'h44, "R7 kept 4", v, 8'h44);
        bread(5'd20, v); check(v[5] == 1'b1, "R7 fifth dropped", v[5], 1);
        bread(5'd16, v); check(v == 8'h44, "R11 empty read", v, 8'h44);
        bread(5'd20, v); check(v[5:3] == 3'b100, "R11 flags unchanged", v[5:3], 4);

        // status register
        bwrite(5'd20, 8'hFF);
        bread(5'd20, v); check(v == 8'hE6, "R9 write ones", v, 8'hE6);
        check(irq == 1'b1, "R12 irq on", irq, 1);
        bwrite(5'd20, 8'h44);
        bread(5'd20, v); check(v == 8'hE4, "R9 clear overrun", v, 8'hE4);
        bwrite(5'd20, 8'h04);
        #1 check(irq == 1'b0, "R12 nothing pending", irq, 0);
        send(8'h6E, 1'b1);
        check(irq == 1'b1, "R12 rx pending", irq, 1);
        bread(5'd16, v); check(v == 8'h6E, "R5 rx byte 2", v, 8'h6E);
        #1 check(irq == 1'b0, "R12 drained", irq, 0);

        // framing error
        send(8'h81, 1'b0);
        repeat (2 * bitc) @(posedge clk);
        bread(5'd20, v); check(v[0] == 1'b1, "R8 frame error", v[0], 1);
        bread(5'd16, v); check(v == 8'h81, "R8 byte kept", v, 8'h81);
        #1 check(irq == 1'b1, "R12 error pending", irq, 1);
        bwrite(5'd20, 8'h05);
        bread(5'd20, v); check(v[0] == 1'b1, "R9 one keeps error", v[0], 1);
        bwrite(5'd20, 8'h04);
        bread(5'd20, v); check(v[0] == 1'b0, "R9 zero clears error", v[0], 0);

        // glitch
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (48) @(negedge clk);
        bread(5'd20, v); check(v[5] == 1'b1 && v[0] == 1'b0, "R10 glitch ignored", v, 8'hA4);

        // read sweep around the delivery of a fifth character
        for (int off = 135; off < 176; off++) begin
            logic [7:0] b1, r0;
            b1 = 8'(off);
            send(b1, 1'b1);
            send(b1 + 8'd1, 1'b1);
            send(b1 + 8'd2, 1'b1);
            send(b1 + 8'd3, 1'b1);
            fork
                send(b1 + 8'd4, 1'b1);
                begin
                    repeat (off) @(negedge clk);
                    bread(5'd16, r0);
                end
            join
            check(r0 == b1, "R7 sweep first", r0, b1);
            for (int k = 1; k < 4; k++) begin
                bread(5'd16, v);
                check(v == b1 + 8'(k), "R7 sweep order", v, b1 + 8'(k));
            end
            bread(5'd20, s);
            if (s[1]) begin
                n_ovr++;
            end else begin
                n_ok++;
                bread(5'd16, v);
                check(v == b1 + 8'd4, "R7 sweep accepted", v, b1 + 8'd4);
            end
            bread(5'd20, v); check(v[5] == 1'b1, "R7 sweep drained", v[5], 1);
            bwrite(5'd20, 8'h04);
        end
        check(n_ovr > 0 && n_ok > 0, "R7 both outcomes", n_ovr, n_ok);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule